// File: doc/BRIEF.md
# Dual-Mode Processor Timer Bank

This block holds one timer per processor, for up to sixteen processors, and a shared mode register in a system window. Each timer runs in one of two modes. In counter mode it counts 500 ns ticks up to a programmable limit. When the count reaches the limit it wraps to zero, sets a reached flag and raises that processor's interrupt. In user mode the same timer becomes a wide count of 54 tick bits. This count is never interrupting, is started and stopped by a run bit, and software reads and writes it as a high word and a low word.

Software reaches the block through a 32-bit register port. The port carries a window select (0 selects the system window, n selects processor n-1) and a word offset. Reads are combinational and are taken in the cycle where `reg_rd` is high. Side effects of a read or a write happen at the next clock edge. One bit per processor in the mode register selects user mode. A mode write affects only the processors whose bit changes. A count update runs on each cycle in which `tick_500ns` is high. Count values appear in bits 30..9 (counter mode) or 62..9 (user mode), so bits 8..0 of every count word read zero.

Top module: `ptmr_bank`

## Requirements
- R1: After reset the mode register is 0, every run bit is 1, every limit and count is 0, no reached flag or interrupt is set, and every timer counts ticks in counter mode.
- R2: In counter mode, offset 0x4 reads {reached, tick count in bits 30..9, zeros in 8..0}. With a nonzero limit L (bits 30..9), the tick that brings the count to L clears the count and sets both reached and the interrupt. With a zero limit the count wraps to 0 at 0x7FFFFE00 and never sets reached. An interrupt is never high without reached.
- R3: In counter mode, a read of offset 0x0 returns the limit (bits 30..9) and clears reached and the interrupt. A tick that reaches the limit in that same cycle wins.
- R4: In counter mode, writing offset 0x0 sets the limit, clears the count and lowers the interrupt. Writing offset 0x8 sets the limit and leaves the count alone. Writing offset 0x4 has no effect.
- R5: The mode register is at system-window offset 0x10, with bit i for processor i, and it reads back as written. A write to offset 0x10 through a processor window is ignored. In the system window, every other offset reads 0, and in a processor window offset 0x10 reads 0.
- R6: When a processor's mode bit goes from 0 to 1, its interrupt is lowered and its counter-mode limit is cleared to 0. Processors whose bit does not change keep their count, limit, flags and interrupt.
- R7: In user mode, offset 0x0 reads {reached, count bits 53..23} and offset 0x4 reads {count bits 22..0, nine zeros}. Neither read has a side effect.
- R8: In user mode, writing offset 0x0 loads count bits 53..23 from data bits 30..0, and writing offset 0x4 loads count bits 22..0 from data bits 31..9. Either write clears reached.
- R9: In user mode, the tick that brings the count to 2^54-1 (0x7FFFFFFFFFFFFE00 as a byte count) wraps the count to 0 and sets reached. The interrupt stays low for the whole time the timer is in user mode.
- R10: Bit 0 at offset 0xC is the run bit, and it reads back as written, with the upper bits zero. In user mode a run bit of 0 freezes the count. In counter mode the count advances whatever the run bit holds.
- R11: When a processor's mode bit goes from 1 to 0, counting resumes in counter mode from count bits 21..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_500ns | input | 1 | Count strobe, one pulse per 500 ns |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_win | input | WIN_W | Window select: 0 system, n processor n-1 |
| reg_ofs | input | 3 | Word offset (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | NUM_PROC | Per-processor interrupt, counter mode only |

## Verification
The bench goes after these corner cases:
- A read of the limit in the same cycle as the tick that reaches it. A design that cleared last would lose the event.
- Entering user mode while an interrupt is pending. A design that kept it would leave a user-mode timer interrupting.
- The user count rolling past its top. A wrong comparison width would never set reached, or would wrap early.
- A mode write that changes only some bits. A design that reinitialised every processor would corrupt the counts of timers left alone.

Stopping through the run bit is exercised in both modes. A design that gated counter mode would freeze a timer that must keep running.

// File: rtl/ptmr_pkg.sv
// Package: shared register offsets and count widths for the processor timer bank.
// Assumes word-indexed offsets (byte offset >> 2).
package ptmr_pkg;
    localparam logic [2:0] OFS_HIGH    = 3'd0;  // limit (counter) / high word (user)
    localparam logic [2:0] OFS_LOW     = 3'd1;  // count+reached (counter) / low word (user)
    localparam logic [2:0] OFS_PRELOAD = 3'd2;  // limit without count reset
    localparam logic [2:0] OFS_RUN     = 3'd3;  // run bit
    localparam logic [2:0] OFS_MODE    = 3'd4;  // mode register, system window only

    localparam int SUB_BITS = 9;                // byte-count bits below one tick
    localparam int NARROW_W = 31 - SUB_BITS;    // counter-mode tick bits (22)
    localparam int WIDE_W   = 63 - SUB_BITS;    // user-mode tick bits (54)
    localparam int HIGH_LSB = 32 - SUB_BITS;    // first tick bit in the high word (23)
endpackage

// File: rtl/ptmr_mode_reg.sv
// Module: per-processor mode bits with 0->1 change detection.
// Assumes wr_en is already decoded to the system window's mode offset.
module ptmr_mode_reg #(
    parameter int NUM_PROC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_PROC-1:0] wdata,
    output logic [NUM_PROC-1:0] mode_q,
    output logic [NUM_PROC-1:0] enter_user
);
    // Entry pulse only for bits that actually move from counter to user mode.
    assign enter_user = wr_en ? (wdata & ~mode_q) : '0;

    // Mode register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else if (wr_en) mode_q <= wdata;
    end

    // R5: a decoded mode write lands exactly as written.
    p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode_q == $past(wdata));
endmodule

// File: rtl/ptmr_unit.sv
// Module: one processor timer, with counter mode (limit/interrupt) and user mode
// (wide count, run-gated, no interrupt).
// Assumes: user_mode is the registered mode bit; enter_user pulses for one cycle
// on a 0->1 mode change; sel/wr/rd are for this unit's window only.
module ptmr_unit
    import ptmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        user_mode,
    input  logic        enter_user,
    input  logic        sel,
    input  logic        wr,
    input  logic        rd,
    input  logic [2:0]  ofs,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    logic [WIDE_W-1:0]   cnt_q;
    logic [NARROW_W-1:0] lim_q;
    logic                reached_q, irq_q, run_q;

    logic [NARROW_W-1:0] narrow_nxt;
    logic [WIDE_W-1:0]   wide_nxt;
    logic                cnt_wr, lim_rd_clr;

    assign narrow_nxt = cnt_q[NARROW_W-1:0] + 1'b1;
    assign wide_nxt   = cnt_q + 1'b1;
    // Count-loading writes: offset 0 in both modes, offset 4 only in user mode.
    assign cnt_wr     = sel && wr && (ofs == OFS_HIGH || (ofs == OFS_LOW && user_mode));
    assign lim_rd_clr = sel && rd && ofs == OFS_HIGH && !user_mode;
    assign irq        = irq_q;

    // Timer state: later statements win (read clear < tick/write < limit/run < mode entry).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else begin
            if (lim_rd_clr) begin
                reached_q <= 1'b0;
                irq_q     <= 1'b0;
            end
            if (cnt_wr) begin
                if (user_mode) begin
                    if (ofs == OFS_HIGH) cnt_q <= {wdata[30:0], cnt_q[HIGH_LSB-1:0]};
                    else                 cnt_q <= {cnt_q[WIDE_W-1:HIGH_LSB], wdata[31:SUB_BITS]};
                    reached_q <= 1'b0;
                end else begin
                    cnt_q <= '0;
                    lim_q <= wdata[30:SUB_BITS];
                    irq_q <= 1'b0;
                end
            end else if (tick) begin
                if (user_mode) begin
                    if (run_q) begin
                        if (&wide_nxt) begin
                            cnt_q     <= '0;
                            reached_q <= 1'b1;
                        end else begin
                            cnt_q <= wide_nxt;
                        end
                    end
                end else if (lim_q != '0 && narrow_nxt == lim_q) begin
                    cnt_q     <= '0;
                    reached_q <= 1'b1;
                    irq_q     <= 1'b1;
                end else if (&narrow_nxt) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= {{(WIDE_W-NARROW_W){1'b0}}, narrow_nxt};
                end
            end
            if (sel && wr && ofs == OFS_PRELOAD) lim_q <= wdata[30:SUB_BITS];
            if (sel && wr && ofs == OFS_RUN)     run_q <= wdata[0];
            if (enter_user) begin
                irq_q <= 1'b0;
                lim_q <= '0;
            end
        end
    end

    // Read view of this unit's registers.
    always_comb begin
        unique case (ofs)
            OFS_HIGH: rdata = user_mode ? {reached_q, cnt_q[WIDE_W-1:HIGH_LSB]}
                                        : {1'b0, lim_q, {SUB_BITS{1'b0}}};
            OFS_LOW:  rdata = user_mode ? {cnt_q[HIGH_LSB-1:0], {SUB_BITS{1'b0}}}
                                        : {reached_q, cnt_q[NARROW_W-1:0], {SUB_BITS{1'b0}}};
            OFS_RUN:  rdata = {31'b0, run_q};
            default:  rdata = '0;
        endcase
    end

    // R9: no interrupt while in user mode.
    p_user_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> !irq_q);
    // R2: interrupt only with reached set.
    p_irq_implies_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> reached_q);
    // R3: a limit read without a tick leaves both flags clear.
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_rd_clr && !tick) |=> (!reached_q && !irq_q));
    // R10: stopped user count holds when untouched.
    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !run_q && !(sel && wr)) |=> $stable(cnt_q));
endmodule

// File: rtl/ptmr_bank.sv
// Module: top of the processor timer bank: window decode, mode register,
// one ptmr_unit per processor, read-data mux.
// Assumes: reg_win 0 is the system window, n is processor n-1; reads are
// combinational and side effects occur at the clock edge.
module ptmr_bank
    import ptmr_pkg::*;
#(
    parameter int NUM_PROC = 4,
    localparam int WIN_W   = $clog2(NUM_PROC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_500ns,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [WIN_W-1:0]    reg_win,
    input  logic [2:0]          reg_ofs,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PROC-1:0] irq
);
    logic [NUM_PROC-1:0] mode_q, enter_user;
    logic [31:0]         unit_rdata [NUM_PROC];
    logic                mode_wr;

    assign mode_wr = reg_wr && reg_win == '0 && reg_ofs == OFS_MODE;

    ptmr_mode_reg #(.NUM_PROC(NUM_PROC)) mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mode_wr),
        .wdata      (reg_wdata[NUM_PROC-1:0]),
        .mode_q     (mode_q),
        .enter_user (enter_user)
    );

    for (genvar i = 0; i < NUM_PROC; i++) begin : g_unit
        ptmr_unit unit_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_500ns),
            .user_mode  (mode_q[i]),
            .enter_user (enter_user[i]),
            .sel        (reg_win == WIN_W'(i + 1)),
            .wr         (reg_wr),
            .rd         (reg_rd),
            .ofs        (reg_ofs),
            .wdata      (reg_wdata),
            .rdata      (unit_rdata[i]),
            .irq        (irq[i])
        );
    end

    // Read mux: system window exposes only the mode register.
    always_comb begin
        reg_rdata = '0;
        if (reg_win == '0) begin
            if (reg_ofs == OFS_MODE) reg_rdata = 32'(mode_q);
        end else begin
            for (int i = 0; i < NUM_PROC; i++)
                if (reg_win == WIN_W'(i + 1)) reg_rdata = unit_rdata[i];
        end
    end

    // R5: writes through processor windows never alter the mode register.
    p_mode_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_win != '0) |=> $stable(mode_q));
endmodule

// File: tb/ptmr_bank_tb.sv
module ptmr_bank_tb_top;
    localparam int NP = 4;
    localparam longint unsigned WMAX = (64'd1 << 54) - 1;
    localparam longint unsigned NMASK = 64'h3FFFFF;

    logic clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
    logic [2:0] win = 0, ofs = 0;
    logic [31:0] wdata = 0, rdata;
    logic [NP-1:0] irq;

    int checks = 0, fails = 0;

    // Reference model state
    longint unsigned m_cnt [NP];
    longint unsigned m_lim [NP];
    bit m_reach [NP], m_irq [NP], m_run [NP];
    bit [NP-1:0] m_mode;

    always #4 clk = ~clk;

    ptmr_bank #(.NUM_PROC(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_500ns(tick), .reg_wr(wr), .reg_rd(rd),
        .reg_win(win), .reg_ofs(ofs), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_cnt[p] = 0; m_lim[p] = 0; m_reach[p] = 0; m_irq[p] = 0; m_run[p] = 1;
        end
        m_mode = '0;
    endtask

    function automatic logic [31:0] exp_read(input int w, input int o);
        int p;
        if (w == 0) return (o == 4) ? 32'(m_mode) : 32'd0;
        if (w > NP) return 0;
        p = w - 1;
        case (o)
            0: return m_mode[p] ? {m_reach[p], 31'(m_cnt[p] >> 23)} : 32'(m_lim[p] << 9);
            1: return m_mode[p] ? 32'((m_cnt[p] & 64'h7FFFFF) << 9)
                                : {m_reach[p], 31'((m_cnt[p] & NMASK) << 9)};
            3: return {31'd0, m_run[p]};
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        for (int p = 0; p < NP; p++) begin
            bit s, u, cw;
            longint unsigned n;
            s = (int'(win) == p + 1);
            u = m_mode[p];
            if (s && rd && ofs == 0 && !u) begin m_reach[p] = 0; m_irq[p] = 0; end
            cw = s && wr && (ofs == 0 || (ofs == 1 && u));
            if (cw) begin
                if (u) begin
                    if (ofs == 0) m_cnt[p] = (longint'(wdata & 32'h7FFFFFFF) << 23) | (m_cnt[p] & 64'h7FFFFF);
                    else          m_cnt[p] = ((m_cnt[p] >> 23) << 23) | longint'(wdata >> 9);
                    m_reach[p] = 0;
                end else begin
                    m_cnt[p] = 0; m_lim[p] = (wdata >> 9) & NMASK; m_irq[p] = 0;
                end
            end else if (tick) begin
                if (u) begin
                    if (m_run[p]) begin
                        if (m_cnt[p] + 1 == WMAX) begin m_cnt[p] = 0; m_reach[p] = 1; end
                        else m_cnt[p] = m_cnt[p] + 1;
                    end
                end else begin
                    n = (m_cnt[p] & NMASK) + 1;
                    if (m_lim[p] != 0 && n == m_lim[p]) begin m_cnt[p] = 0; m_reach[p] = 1; m_irq[p] = 1; end
                    else if (n == NMASK) m_cnt[p] = 0;
                    else m_cnt[p] = n;
                end
            end
            if (s && wr && ofs == 2) m_lim[p] = (wdata >> 9) & NMASK;
            if (s && wr && ofs == 3) m_run[p] = wdata[0];
            if (win == 0 && wr && ofs == 4 && wdata[p] && !u) begin m_irq[p] = 0; m_lim[p] = 0; end
        end
        if (win == 0 && wr && ofs == 4) m_mode = wdata[NP-1:0];
    endtask

    // One bus cycle; entered and left at a falling edge. Read data and irq compared.
    task automatic cyc(input bit t, input bit w, input bit r, input int wi, input int o,
                       input logic [31:0] d, input string req);
        logic [NP-1:0] ei;
        tick = t; wr = w; rd = r; win = 3'(wi); ofs = 3'(o); wdata = d;
        #1;
        if (r) check(rdata, exp_read(wi, o), req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++) ei[p] = m_irq[p];
        check(32'(irq), 32'(ei), {req, " irq"});
        tick = 0; wr = 0; rd = 0;
    endtask

    task automatic ticks(input int n, input string req);
        for (int k = 0; k < n; k++) cyc(1, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int w = 1; w <= NP; w++) begin
            cyc(0, 0, 1, w, 1, 0, "R1 count");
            cyc(0, 0, 1, w, 3, 0, "R1 run");
        end
        cyc(0, 0, 1, 0, 4, 0, "R1 mode");
        ticks(3, "R1 free count");
        cyc(0, 0, 1, 2, 1, 0, "R1 counting");
        // R4/R2: limit 5 ticks on processor 0
        cyc(0, 1, 0, 1, 0, 32'(5 << 9), "R4 limit write");
        cyc(0, 0, 1, 1, 1, 0, "R4 count cleared");
        ticks(4, "R2 before limit");
        cyc(0, 0, 1, 1, 1, 0, "R2 count at 4");
        ticks(1, "R2 reach");
        cyc(0, 0, 1, 1, 1, 0, "R2 reached bit");
        cyc(0, 0, 1, 1, 0, 0, "R3 limit read clears");
        cyc(0, 0, 1, 1, 1, 0, "R3 reached cleared");
        // R3: read in the same cycle as the reaching tick
        ticks(4, "R3 approach");
        cyc(1, 0, 1, 1, 0, 0, "R3 tick wins");
        cyc(0, 0, 1, 1, 1, 0, "R3 reached kept");
        // R4: preload without reset, low write ignored
        ticks(2, "R4 advance");
        cyc(0, 1, 0, 1, 2, 32'(9 << 9), "R4 preload");
        cyc(0, 0, 1, 1, 1, 0, "R4 count kept");
        cyc(0, 1, 0, 1, 1, 32'hFFFF_FE00, "R4 low write ignored");
        cyc(0, 0, 1, 1, 1, 0, "R4 low unchanged");
        cyc(0, 0, 1, 1, 0, 0, "R4 preload readback");
        // R2: zero limit never reaches
        ticks(40, "R2 free run");
        cyc(0, 0, 1, 3, 1, 0, "R2 no reached at zero limit");
        // R5: window rules
        cyc(0, 1, 0, 2, 4, 32'hF, "R5 proc window mode write");
        cyc(0, 0, 1, 0, 4, 0, "R5 mode unchanged");
        cyc(0, 0, 1, 0, 3, 0, "R5 system status zero");
        cyc(0, 0, 1, 0, 0, 0, "R5 system ofs0 zero");
        cyc(0, 0, 1, 2, 4, 0, "R5 proc ofs 0x10 zero");
        // R6: enter user with interrupt pending on processor 0
        cyc(0, 1, 0, 1, 0, 32'(3 << 9), "R6 setup limit");
        ticks(3, "R6 raise irq");
        cyc(0, 1, 0, 0, 4, 32'h1, "R6 enter user");
        cyc(0, 0, 1, 0, 4, 0, "R5 mode readback");
        cyc(0, 0, 1, 1, 0, 0, "R7 high read");
        ticks(5, "R10 running user");
        cyc(0, 0, 1, 1, 1, 0, "R7 low read");
        cyc(0, 1, 0, 1, 3, 0, "R10 stop");
        cyc(0, 0, 1, 1, 3, 0, "R10 run readback");
        ticks(6, "R10 stopped");
        cyc(0, 0, 1, 1, 1, 0, "R10 frozen");
        // R8/R9: load near top and roll over
        cyc(0, 1, 0, 1, 0, 32'h7FFF_FFFF, "R8 high write");
        cyc(0, 1, 0, 1, 1, 32'hFFFF_FC00, "R8 low write");
        cyc(0, 0, 1, 1, 0, 0, "R8 high readback");
        cyc(0, 0, 1, 1, 1, 0, "R8 low readback");
        cyc(0, 1, 0, 1, 3, 1, "R10 start");
        ticks(1, "R9 top");
        cyc(0, 0, 1, 1, 0, 0, "R9 reached in high word");
        cyc(0, 0, 1, 1, 1, 0, "R9 wrapped low");
        cyc(0, 1, 0, 1, 1, 32'h0000_4000, "R8 write clears reached");
        cyc(0, 0, 1, 1, 0, 0, "R8 reached cleared");
        // R6: partial mode change keeps processor 0
        cyc(0, 1, 0, 2, 0, 32'(2 << 9), "R6 proc1 limit");
        cyc(0, 1, 0, 0, 4, 32'h3, "R6 proc1 enters");
        cyc(0, 0, 1, 1, 1, 0, "R6 proc0 untouched");
        cyc(0, 0, 1, 2, 3, 0, "R6 proc1 run");
        // R11: leave user; counter mode counts regardless of run
        cyc(0, 1, 0, 1, 3, 0, "R10 run off");
        cyc(0, 1, 0, 0, 4, 32'h2, "R11 leave user");
        ticks(3, "R11 counting");
        cyc(0, 0, 1, 1, 1, 0, "R11 count resumed");
        cyc(0, 0, 1, 1, 0, 0, "R6 limit cleared on entry");
        // Mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            int w, o;
            logic [31:0] d;
            w = $urandom_range(0, NP);
            o = $urandom_range(0, 4);
            d = $urandom;
            if (o != 4 && o != 3) d = d & 32'h0000_1E00;
            case ($urandom_range(0, 3))
                0: cyc($urandom_range(0, 1) == 1, 1, 0, w, o, d, "R2 mixed write");
                1: cyc($urandom_range(0, 1) == 1, 0, 1, w, o, 0, "R7 mixed read");
                default: cyc(1, 0, 0, 0, 0, 0, "R2 mixed tick");
            endcase
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule